// File: doc/BRIEF.md
# SDRAM Command Monitor

This block sits beside the control pins of a four-bank synchronous DRAM with a 32-bit data bus and classifies, every clock cycle, the command currently present on those pins. It takes the clock-enable level of the previous and the current cycle, chip select, the three strobe pins (row strobe, column strobe, write enable), the two bank-select bits and eleven address lines. From these it presents a decoded command code together with the target bank, the row or column address and the auto-precharge request. All of these outputs are combinational, so they are valid in the same cycle as the pins.

Internally it records, per bank, whether a row is open, and it counts down a short lockout after a mode-register write. A command that breaks a sequencing rule raises `violation` for the cycle it is present. Such a command is then ignored by the bank tracker. The open-bank vector is brought out so that the tracked state can be observed.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cke_prev`=1, `cke`=1 and `cs_n`=0, the strobe pins {ras_n,cas_n,we_n} decode to: 000 MRS(2), 001 AREF(3), 011 ACT(5), 101 READ(6), 100 WRITE(7), 110 BST(8), 010 precharge (9 when addr[10]=0, 10 when addr[10]=1), 111 NOP(1). The value in brackets is the `cmd` code.
- R2: With `cke_prev`=1, `cke`=0, `cs_n`=0 and strobes 001, `cmd` is SREF entry (4). If any bank is open, this is a violation.
- R3: `cke_prev`=0 with `cke`=1 gives `cmd`=EXIT (11). `violation` is raised unless `cs_n`=1 or the strobes are 111. `cke_prev`=0 with `cke`=0 gives `cmd`=HOLD (14).
- R4: `cke_prev`=1 with `cke`=0 that is not a self-refresh entry gives `cmd`=12 (clock suspend / active power-down) if any bank is open, and 13 (precharge power-down) otherwise.
- R5: On READ or WRITE, `cmd_addr` is {3'b0, addr[7:0]} and `auto_pre` equals addr[10]. An accepted access with `auto_pre`=1 closes its bank at the clock edge.
- R6: An accepted precharge with addr[10]=0 closes only bank `ba`. With addr[10]=1 it closes all banks.
- R7: `ba` values 0,1,2,3 select banks A,B,C,D, which are `bank_open` bits 0..3. An accepted ACT sets bit `ba` and presents the full row on `cmd_addr`. `cmd_bank` equals `ba` for ACT, READ, WRITE and single-bank precharge, and is 0 otherwise.
- R8: MRS while any bank is open raises `violation`.
- R9: After an accepted MRS, any command in the next 2 cycles other than NOP or deselect (`cs_n`=1) raises `violation`.
- R10: AREF while any bank is open raises `violation`.
- R11: READ or WRITE to a closed bank, or ACT to an open bank, raises `violation`. Any command flagged by `violation` leaves `bank_open` unchanged.
- R12: `cs_n`=1 with `cke_prev`=`cke`=1 gives `cmd`=DESEL (0) and leaves `bank_open` unchanged.
- R13: Synchronous `rst` clears `bank_open` to 0 and clears the lockout. `violation` is 0 while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke_prev | input | 1 | Clock enable sampled in the previous cycle |
| cke | input | 1 | Clock enable in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Address lines A10..A0 |
| cmd | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Target bank of the command |
| cmd_addr | output | 11 | Row address (ACT) or column address (READ/WRITE) |
| auto_pre | output | 1 | Auto-precharge request on READ/WRITE |
| violation | output | 1 | Sequencing rule broken this cycle |
| bank_open | output | 4 | Per-bank open-row flags |

## Verification
The inline assertions check, on every cycle, the rules that tie the decoded command to the tracked state: bank opening and closing after accepted commands, the all-idle condition for MRS and refresh, the MRS lockout, and deselect stability. Only the bench scenarios can show that the decode table itself is correct. The same holds for the split of clock-enable transitions into self-refresh, suspend and precharge power-down, the address and auto-precharge fields, and the clearing of the lockout by reset. These are covered by walking a fixed command script with known expected codes.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BA_W    = 2,
  parameter int ADDR_W  = 11,
  parameter int COL_W   = 8,
  parameter int AP_BIT  = 10,
  parameter int MRS_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_prev,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              auto_pre,
  output logic              violation,
  output logic [(1<<BA_W)-1:0] bank_open
);
  localparam int NB     = 1 << BA_W;
  localparam int LOCK_W = $clog2(MRS_GAP + 1);

  localparam logic [3:0] C_DESEL = 4'd0,  C_NOP  = 4'd1,  C_MRS  = 4'd2,  C_AREF = 4'd3,
                         C_SREF  = 4'd4,  C_ACT  = 4'd5,  C_RD   = 4'd6,  C_WR   = 4'd7,
                         C_BST   = 4'd8,  C_PRE  = 4'd9,  C_PREA = 4'd10, C_EXIT = 4'd11,
                         C_APD   = 4'd12, C_PPD  = 4'd13, C_HOLD = 4'd14;

  logic [2:0]        pins;
  logic              quiet, any_open, busy, raw_viol;
  logic [LOCK_W-1:0] lock_cnt;

  assign pins     = {ras_n, cas_n, we_n};
  assign quiet    = cs_n || (pins == 3'b111);
  assign any_open = |bank_open;
  assign busy     = (lock_cnt != '0);

  always_comb begin
    if (!cke_prev && cke)      cmd = C_EXIT;
    else if (!cke_prev)        cmd = C_HOLD;
    else if (!cke)             cmd = (!cs_n && pins == 3'b001) ? C_SREF : (any_open ? C_APD : C_PPD);
    else if (cs_n)             cmd = C_DESEL;
    else begin
      case (pins)
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_AREF;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = addr[AP_BIT] ? C_PREA : C_PRE;
        default: cmd = C_NOP;
      endcase
    end
  end

  always_comb begin
    case (cmd)
      C_EXIT:               raw_viol = !quiet;
      C_MRS, C_AREF, C_SREF: raw_viol = any_open;
      C_RD, C_WR:           raw_viol = !bank_open[ba];
      C_ACT:                raw_viol = bank_open[ba];
      default:              raw_viol = 1'b0;
    endcase
    if (busy && !quiet) raw_viol = 1'b1;
  end

  assign violation = !rst && raw_viol;

  wire rw = (cmd == C_RD) || (cmd == C_WR);
  assign auto_pre = rw && addr[AP_BIT];
  assign cmd_bank = (rw || cmd == C_ACT || cmd == C_PRE) ? ba : '0;
  assign cmd_addr = (cmd == C_ACT) ? addr :
                    rw ? ADDR_W'(addr[COL_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= '0;
    end else if (!violation) begin
      case (cmd)
        C_ACT:      bank_open[ba] <= 1'b1;
        C_RD, C_WR: if (addr[AP_BIT]) bank_open[ba] <= 1'b0;
        C_PRE:      bank_open[ba] <= 1'b0;
        C_PREA:     bank_open <= '0;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             lock_cnt <= '0;
    else if (cmd == C_MRS && !violation) lock_cnt <= LOCK_W'(MRS_GAP);
    else if (busy)                       lock_cnt <= lock_cnt - 1'b1;
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT && !violation) |=> bank_open[$past(ba)]); // R7
  AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_PREA && !violation) |=> (bank_open == '0)); // R6
  AST_MRS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_MRS && bank_open != '0) |-> violation); // R8
  AST_AREF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_AREF && bank_open != '0) |-> violation); // R10
  AST_MRS_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_MRS && !violation) |=> (quiet || violation)); // R9
  AST_RW_CLOSED: assert property (@(posedge clk) disable iff (rst)
    ((cmd == C_RD || cmd == C_WR) && !bank_open[ba]) |-> violation); // R11
  AST_VIOL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    violation |=> $stable(bank_open)); // R11
  AST_DESEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_DESEL) |=> $stable(bank_open)); // R12
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (bank_open == '0)); // R13
endmodule

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  logic clk = 0, rst = 1;
  logic cke_prev = 1, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [10:0] addr = 0;
  logic [3:0] cmd, bank_open;
  logic [1:0] cmd_bank;
  logic [10:0] cmd_addr;
  logic auto_pre, violation;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor u0 (.clk, .rst, .cke_prev, .cke, .cs_n, .ras_n, .cas_n, .we_n,
    .ba, .addr, .cmd, .cmd_bank, .cmd_addr, .auto_pre, .violation, .bank_open);

  // {req, cke_prev, cke, cs_n, rcw, ba, addr, exp_cmd, exp_viol, exp_open, exp_addr, exp_ap}
  localparam int NV = 32;
  localparam logic [43:0] TBL [NV] = '{
    {4'd7, 1'b1,1'b1,1'b0,3'b011,2'd0,11'h123, 4'd5, 1'b0,4'b0000,11'h123,1'b0}, // R7 act A
    {4'd7, 1'b1,1'b1,1'b0,3'b011,2'd1,11'h045, 4'd5, 1'b0,4'b0001,11'h045,1'b0}, // R7 act B
    {4'd5, 1'b1,1'b1,1'b0,3'b101,2'd0,11'h4AB, 4'd6, 1'b0,4'b0011,11'h0AB,1'b1}, // R5 read+AP
    {4'd5, 1'b1,1'b1,1'b0,3'b100,2'd1,11'h0FF, 4'd7, 1'b0,4'b0010,11'h0FF,1'b0}, // R5 write
    {4'd11,1'b1,1'b1,1'b0,3'b101,2'd0,11'h010, 4'd6, 1'b1,4'b0010,11'h010,1'b0}, // R11 read closed
    {4'd11,1'b1,1'b1,1'b0,3'b011,2'd1,11'h077, 4'd5, 1'b1,4'b0010,11'h077,1'b0}, // R11 act open
    {4'd8, 1'b1,1'b1,1'b0,3'b000,2'd0,11'h000, 4'd2, 1'b1,4'b0010,11'h000,1'b0}, // R8
    {4'd10,1'b1,1'b1,1'b0,3'b001,2'd0,11'h000, 4'd3, 1'b1,4'b0010,11'h000,1'b0}, // R10
    {4'd4, 1'b1,1'b0,1'b1,3'b111,2'd0,11'h000, 4'd12,1'b0,4'b0010,11'h000,1'b0}, // R4 suspend
    {4'd3, 1'b0,1'b0,1'b1,3'b111,2'd0,11'h000, 4'd14,1'b0,4'b0010,11'h000,1'b0}, // R3 hold
    {4'd3, 1'b0,1'b1,1'b0,3'b111,2'd0,11'h000, 4'd11,1'b0,4'b0010,11'h000,1'b0}, // R3 exit
    {4'd6, 1'b1,1'b1,1'b0,3'b010,2'd1,11'h000, 4'd9, 1'b0,4'b0010,11'h000,1'b0}, // R6 pre B
    {4'd1, 1'b1,1'b1,1'b0,3'b110,2'd0,11'h000, 4'd8, 1'b0,4'b0000,11'h000,1'b0}, // R1 bst
    {4'd8, 1'b1,1'b1,1'b0,3'b000,2'd0,11'h000, 4'd2, 1'b0,4'b0000,11'h000,1'b0}, // R8 mrs ok
    {4'd9, 1'b1,1'b1,1'b0,3'b011,2'd2,11'h055, 4'd5, 1'b1,4'b0000,11'h055,1'b0}, // R9 locked
    {4'd9, 1'b1,1'b1,1'b0,3'b111,2'd0,11'h000, 4'd1, 1'b0,4'b0000,11'h000,1'b0}, // R9 nop
    {4'd9, 1'b1,1'b1,1'b0,3'b011,2'd3,11'h3FF, 4'd5, 1'b0,4'b0000,11'h3FF,1'b0}, // R9 free
    {4'd6, 1'b1,1'b1,1'b0,3'b010,2'd0,11'h400, 4'd10,1'b0,4'b1000,11'h000,1'b0}, // R6 all
    {4'd10,1'b1,1'b1,1'b0,3'b001,2'd0,11'h000, 4'd3, 1'b0,4'b0000,11'h000,1'b0}, // R10 ok
    {4'd2, 1'b1,1'b0,1'b0,3'b001,2'd0,11'h000, 4'd4, 1'b0,4'b0000,11'h000,1'b0}, // R2 sref
    {4'd3, 1'b0,1'b0,1'b1,3'b111,2'd0,11'h000, 4'd14,1'b0,4'b0000,11'h000,1'b0}, // R3 hold
    {4'd3, 1'b0,1'b1,1'b0,3'b011,2'd0,11'h000, 4'd11,1'b1,4'b0000,11'h000,1'b0}, // R3 bad exit
    {4'd4, 1'b1,1'b0,1'b1,3'b111,2'd0,11'h000, 4'd13,1'b0,4'b0000,11'h000,1'b0}, // R4 ppd
    {4'd3, 1'b0,1'b1,1'b1,3'b111,2'd0,11'h000, 4'd11,1'b0,4'b0000,11'h000,1'b0}, // R3 exit
    {4'd12,1'b1,1'b1,1'b1,3'b000,2'd3,11'h7FF, 4'd0, 1'b0,4'b0000,11'h000,1'b0}, // R12
    {4'd7, 1'b1,1'b1,1'b0,3'b011,2'd2,11'h001, 4'd5, 1'b0,4'b0000,11'h001,1'b0}, // R7 act C
    {4'd5, 1'b1,1'b1,1'b0,3'b100,2'd2,11'h4CD, 4'd7, 1'b0,4'b0100,11'h0CD,1'b1}, // R5 wr+AP
    {4'd7, 1'b1,1'b1,1'b0,3'b011,2'd0,11'h200, 4'd5, 1'b0,4'b0000,11'h200,1'b0}, // R7 act A
    {4'd2, 1'b1,1'b0,1'b0,3'b001,2'd0,11'h000, 4'd4, 1'b1,4'b0001,11'h000,1'b0}, // R2 busy
    {4'd3, 1'b0,1'b1,1'b1,3'b111,2'd0,11'h000, 4'd11,1'b0,4'b0001,11'h000,1'b0}, // R3 exit
    {4'd12,1'b1,1'b1,1'b1,3'b011,2'd1,11'h000, 4'd0, 1'b0,4'b0001,11'h000,1'b0}, // R12
    {4'd12,1'b1,1'b1,1'b0,3'b111,2'd0,11'h000, 4'd1, 1'b0,4'b0001,11'h000,1'b0}  // R12 kept
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic kp, input logic k, input logic cs, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [10:0] a);
    @(negedge clk);
    cke_prev = kp; cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    #1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1;
    drive(1, 1, 1, 3'b111, 0, 0);
    drive(1, 1, 1, 3'b111, 0, 0);
    chk("R13 no violation in reset", violation, 0);
    rst = 0;
    drive(1, 1, 1, 3'b111, 0, 0);
    chk("R13 open after reset", bank_open, 0);
    chk("R12 deselect code", cmd, 0);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = TBL[i];
      drive(v[39], v[38], v[37], v[36:34], v[33:32], v[31:21]);
      n_vec++;
      if (cmd != v[20:17] || violation != v[16] || bank_open != v[15:12] ||
          cmd_addr != v[11:1] || auto_pre != v[0]) begin
        n_bad++;
        $display("FAIL R%0d row %0d actual cmd=%0d viol=%0b open=%b addr=%h ap=%0b expected cmd=%0d viol=%0b open=%b addr=%h ap=%0b",
                 v[43:40], i, cmd, violation, bank_open, cmd_addr, auto_pre,
                 v[20:17], v[16], v[15:12], v[11:1], v[0]);
      end
    end

    // R7 bank field and R1 precharge bank on outputs
    drive(1, 1, 0, 3'b011, 3, 11'h011);
    chk("R7 cmd_bank on act D", cmd_bank, 3);
    chk("R7 act D accepted", violation, 0);
    drive(1, 1, 0, 3'b111, 2, 0);
    chk("R7 open D and A", bank_open, 4'b1001);
    chk("R7 cmd_bank zero on nop", cmd_bank, 0);
    drive(1, 1, 0, 3'b010, 2, 11'h400);
    chk("R6 prea code", cmd, 10);
    chk("R1 prea no bank", cmd_bank, 0);
    drive(1, 1, 0, 3'b000, 0, 0);
    chk("R8 mrs accepted when idle", violation, 0);
    // R13 reset during lockout
    rst = 1;
    drive(1, 1, 1, 3'b111, 0, 0);
    rst = 0;
    drive(1, 1, 0, 3'b011, 1, 11'h033);
    chk("R13 lockout cleared", violation, 0);
    chk("R13 open cleared", bank_open, 0);
    drive(1, 1, 1, 3'b111, 0, 0);
    chk("R7 act after reset opened B", bank_open, 4'b0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule